// File: doc/BRIEF.md
# Register-Test Branch Resolver

This block settles control flow for a 32-bit core. Each cycle it takes the address of the current instruction, the value read from its D operand register, a 9-bit signed relative field, an absolute target and a 3-bit branch kind. From these it produces three things: whether the branch is taken, the address of the next instruction, and a return address with a write strobe for call forms.

Conditional kinds look at the D register value itself, never at a flag. The zero and nonzero kinds test the whole 32-bit word. The sign kinds test bit 31. Relative displacements count whole 4-byte instructions. They are applied to the byte address of the instruction that follows the branch, so the reach is -256 to +255 instructions. Two call kinds always jump and ask for the sequential address to be stored; neither touches the flags. Every result is registered, so the outputs show the inputs from the previous clock edge.

Top module: `brx_branch_unit`

## Requirements
- R1: While rst is high at a clock edge, taken_o, npc_o, link_we_o and link_o are all zero after that edge.
- R2: Every output reflects the inputs sampled at the previous rising edge (one cycle of latency), for any mix of kinds and operands.
- R3: Kind 3'd1 (test zero) is taken exactly when all 32 bits of dval_i are zero.
- R4: Kind 3'd2 (test nonzero) is taken exactly when dval_i has at least one bit set.
- R5: Kind 3'd3 (test sign set) is taken exactly when dval_i[31] is 1. Kind 3'd4 (test sign clear) is taken exactly when dval_i[31] is 0.
- R6: For a taken kind 1 to 5, npc_o equals pc_i + 4 + 4 * roff_i, with roff_i read as two's complement and the sum taken modulo 2^32.
- R7: When the branch is not taken, npc_o equals pc_i + 4 modulo 2^32.
- R8: Kind 3'd5 (relative call) is always taken, asserts link_we_o and jumps as in R6. link_o always equals pc_i + 4.
- R9: Kind 3'd6 (absolute call) is always taken, asserts link_we_o and sets npc_o to atgt_i.
- R10: Kinds 3'd0 and 3'd7 are never taken and never assert link_we_o. Kinds 1 to 4 never assert link_we_o.
- R11: The extreme displacements 9'h100 (-256 instructions) and 9'h0FF (+255 instructions) give targets of pc+4-1024 and pc+4+1020, wrapping modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kind_i | input | 3 | Branch kind: 0 none, 1 zero, 2 nonzero, 3 sign set, 4 sign clear, 5 relative call, 6 absolute call, 7 none |
| pc_i | input | 32 | Byte address of the current instruction |
| dval_i | input | 32 | D register contents under test |
| roff_i | input | 9 | Signed relative displacement in instructions |
| atgt_i | input | 32 | Absolute target for the absolute call |
| taken_o | output | 1 | Branch taken (registered) |
| npc_o | output | 32 | Next instruction address (registered) |
| link_we_o | output | 1 | Return-address write strobe (registered) |
| link_o | output | 32 | Return address, pc + 4 (registered) |

## Verification
The assertions assume that kind_i, pc_i, dval_i and atgt_i are driven to known values on every clock edge after reset, because each check compares an output with the inputs from one edge earlier. The assertions also assume nothing about alignment of pc_i, so arithmetic is checked modulo 2^32. The stimulus changes inputs only on falling edges. It walks all eight kind codes, both polarities of the zero and sign tests, the two extreme displacements and wrap-around at address zero. It then runs a long stretch of unconstrained values in which every kind code, including the spare ones, appears.

// File: rtl/brx_pkg.sv
package brx_pkg;

  typedef enum logic [2:0] {
    BK_NONE  = 3'd0,
    BK_ZERO  = 3'd1,
    BK_NZERO = 3'd2,
    BK_NEG   = 3'd3,
    BK_POS   = 3'd4,
    BK_CALLR = 3'd5,
    BK_CALLA = 3'd6,
    BK_SPARE = 3'd7
  } br_kind_e;

  typedef struct packed {
    logic take;
    logic use_abs;
    logic save_ret;
  } br_dec_t;

endpackage

// File: rtl/brx_cond.sv
module brx_cond
  import brx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  br_kind_e          kind,
  input  logic [XLEN-1:0]   dval,
  output br_dec_t           dec
);

  localparam int SIGN_BIT = XLEN - 1;

  logic is_zero;
  logic is_neg;

  always_comb begin
    is_zero = (dval == '0);
    is_neg  = dval[SIGN_BIT];
  end

  always_comb begin
    dec = '0;
    unique case (kind)
      BK_ZERO:  dec.take = is_zero;
      BK_NZERO: dec.take = !is_zero;
      BK_NEG:   dec.take = is_neg;
      BK_POS:   dec.take = !is_neg;
      BK_CALLR: begin
        dec.take     = 1'b1;
        dec.save_ret = 1'b1;
      end
      BK_CALLA: begin
        dec.take     = 1'b1;
        dec.use_abs  = 1'b1;
        dec.save_ret = 1'b1;
      end
      default:  dec = '0;
    endcase
  end

endmodule

// File: rtl/brx_target.sv
module brx_target #(
  parameter int XLEN        = 32,
  parameter int OFF_W       = 9,
  parameter int INSN_BYTES  = 4
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [OFF_W-1:0] roff,
  input  logic [XLEN-1:0]  atgt,
  input  logic             use_abs,
  output logic [XLEN-1:0]  seq_pc,
  output logic [XLEN-1:0]  jmp_pc
);

  localparam int             SHIFT = $clog2(INSN_BYTES);
  localparam int             EXT_W = XLEN - OFF_W;
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] off_ext;
  logic [XLEN-1:0] off_bytes;
  logic [XLEN-1:0] rel_pc;

  always_comb begin
    off_ext   = {{EXT_W{roff[OFF_W-1]}}, roff};
    off_bytes = off_ext << SHIFT;
    seq_pc    = pc + STEP;
    rel_pc    = seq_pc + off_bytes;
    jmp_pc    = use_abs ? atgt : rel_pc;
  end

endmodule

// File: rtl/brx_out_reg.sv
module brx_out_reg #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_d,
  input  logic [XLEN-1:0] npc_d,
  input  logic            we_d,
  input  logic [XLEN-1:0] link_d,
  output logic            take_q,
  output logic [XLEN-1:0] npc_q,
  output logic            we_q,
  output logic [XLEN-1:0] link_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      take_q <= 1'b0;
      npc_q  <= '0;
      we_q   <= 1'b0;
      link_q <= '0;
    end else begin
      take_q <= take_d;
      npc_q  <= npc_d;
      we_q   <= we_d;
      link_q <= link_d;
    end
  end

endmodule

// File: rtl/brx_branch_unit.sv
module brx_branch_unit
  import brx_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int OFF_W      = 9,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        kind_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   dval_i,
  input  logic [OFF_W-1:0]  roff_i,
  input  logic [XLEN-1:0]   atgt_i,
  output logic              taken_o,
  output logic [XLEN-1:0]   npc_o,
  output logic              link_we_o,
  output logic [XLEN-1:0]   link_o
);

  br_kind_e        kind;
  br_dec_t         dec;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] jmp_pc;
  logic [XLEN-1:0] npc_d;

  assign kind = br_kind_e'(kind_i);

  brx_cond #(.XLEN(XLEN)) u_cond (
    .kind (kind),
    .dval (dval_i),
    .dec  (dec)
  );

  brx_target #(
    .XLEN       (XLEN),
    .OFF_W      (OFF_W),
    .INSN_BYTES (INSN_BYTES)
  ) u_tgt (
    .pc      (pc_i),
    .roff    (roff_i),
    .atgt    (atgt_i),
    .use_abs (dec.use_abs),
    .seq_pc  (seq_pc),
    .jmp_pc  (jmp_pc)
  );

  assign npc_d = dec.take ? jmp_pc : seq_pc;

  brx_out_reg #(.XLEN(XLEN)) u_oreg (
    .clk    (clk),
    .rst    (rst),
    .take_d (dec.take),
    .npc_d  (npc_d),
    .we_d   (dec.save_ret),
    .link_d (seq_pc),
    .take_q (taken_o),
    .npc_q  (npc_o),
    .we_q   (link_we_o),
    .link_q (link_o)
  );

endmodule

// File: rtl/brx_branch_chk.sv
module brx_branch_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      kind_i,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] dval_i,
  input logic [XLEN-1:0] atgt_i,
  input logic            taken_o,
  input logic [XLEN-1:0] npc_o,
  input logic            link_we_o,
  input logic [XLEN-1:0] link_o
);

  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  // high once the output stage has loaded real inputs since reset
  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!taken_o && !link_we_o && npc_o == '0 && link_o == '0));

  p_zero_test_r3: assert property (@(posedge clk) disable iff (rst || !primed)
    ($past(kind_i) == 3'd1) |-> (taken_o == ($past(dval_i) == '0)));

  p_nonzero_test_r4: assert property (@(posedge clk) disable iff (rst || !primed)
    ($past(kind_i) == 3'd2) |-> (taken_o == ($past(dval_i) != '0)));

  p_sign_set_r5: assert property (@(posedge clk) disable iff (rst || !primed)
    ($past(kind_i) == 3'd3) |-> (taken_o == $past(dval_i[XLEN-1])));

  p_sign_clear_r5: assert property (@(posedge clk) disable iff (rst || !primed)
    ($past(kind_i) == 3'd4) |-> (taken_o == !$past(dval_i[XLEN-1])));

  p_fallthrough_r7: assert property (@(posedge clk) disable iff (rst || !primed)
    !taken_o |-> (npc_o == $past(pc_i) + STEP));

  p_ret_addr_r8: assert property (@(posedge clk) disable iff (rst || !primed)
    ($past(kind_i) == 3'd5) |-> (taken_o && link_we_o && link_o == $past(pc_i) + STEP));

  p_abs_call_r9: assert property (@(posedge clk) disable iff (rst || !primed)
    ($past(kind_i) == 3'd6) |-> (taken_o && link_we_o && npc_o == $past(atgt_i)));

  p_strobe_calls_only_r10: assert property (@(posedge clk) disable iff (rst || !primed)
    link_we_o |-> (taken_o && ($past(kind_i) == 3'd5 || $past(kind_i) == 3'd6)));

endmodule

bind brx_branch_unit brx_branch_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_brx_branch_unit.sv
module sim_brx_branch_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  kind_i = '0;
  logic [31:0] pc_i = '0;
  logic [31:0] dval_i = '0;
  logic [8:0]  roff_i = '0;
  logic [31:0] atgt_i = '0;
  logic        taken_o;
  logic [31:0] npc_o;
  logic        link_we_o;
  logic [31:0] link_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic        q_take[$];
  logic [31:0] q_npc[$];
  logic        q_we[$];
  logic [31:0] q_link[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  brx_branch_unit u0 (
    .clk(clk), .rst(rst), .kind_i(kind_i), .pc_i(pc_i), .dval_i(dval_i),
    .roff_i(roff_i), .atgt_i(atgt_i), .taken_o(taken_o), .npc_o(npc_o),
    .link_we_o(link_we_o), .link_o(link_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: integers and a queue of expectations
  task automatic predict(input int k, input logic [31:0] pc, input logic [31:0] d,
                         input logic [8:0] ro, input logic [31:0] at, input string tag);
    bit take;
    longint off;
    longint tgt;
    longint seq;
    seq = (longint'(pc) + 4) & 64'hFFFF_FFFF;
    off = (ro >= 9'd256) ? longint'(ro) - 512 : longint'(ro);
    case (k)
      1: take = (d == 0);
      2: take = (d != 0);
      3: take = d[31];
      4: take = !d[31];
      5, 6: take = 1;
      default: take = 0;
    endcase
    if (!take)       tgt = seq;
    else if (k == 6) tgt = longint'(at);
    else             tgt = (seq + off * 4) & 64'hFFFF_FFFF;
    q_take.push_back(take);
    q_npc.push_back(tgt[31:0]);
    q_we.push_back(k == 5 || k == 6);
    q_link.push_back(seq[31:0]);
    q_tag.push_back(tag);
  endtask

  task automatic compare_pending();
    string t;
    if (q_tag.size() == 0) return;
    t = q_tag.pop_front();
    check(t, "taken", {31'd0, taken_o}, {31'd0, q_take.pop_front()});
    check(t, "npc", npc_o, q_npc.pop_front());
    check(t, "link_we", {31'd0, link_we_o}, {31'd0, q_we.pop_front()});
    check(t, "link", link_o, q_link.pop_front());
  endtask

  task automatic step(input int k, input logic [31:0] pc, input logic [31:0] d,
                      input logic [8:0] ro, input logic [31:0] at, input string tag);
    @(negedge clk);
    compare_pending();
    rst    = 1'b0;
    kind_i = k[2:0];
    pc_i   = pc;
    dval_i = d;
    roff_i = ro;
    atgt_i = at;
    predict(k, pc, d, ro, at, tag);
  endtask

  initial begin
    kind_i = 3'd5; pc_i = 32'h1234; dval_i = 32'h1; atgt_i = 32'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs cleared while reset is applied
    check("R1", "taken", {31'd0, taken_o}, 32'd0);
    check("R1", "npc", npc_o, 32'd0);
    check("R1", "link_we", {31'd0, link_we_o}, 32'd0);
    check("R1", "link", link_o, 32'd0);

    step(1, 32'h100, 32'h0,        9'd3,   32'h0, "R3");
    step(1, 32'h100, 32'h1,        9'd3,   32'h0, "R3");
    step(1, 32'h100, 32'h8000_0000, 9'd3,  32'h0, "R3");
    step(2, 32'h200, 32'h0,        9'd5,   32'h0, "R4");
    step(2, 32'h200, 32'h0000_0040, 9'd5,  32'h0, "R4");
    step(3, 32'h300, 32'h8000_0000, 9'h1F0, 32'h0, "R5");
    step(3, 32'h300, 32'h7FFF_FFFF, 9'h1F0, 32'h0, "R5");
    step(4, 32'h300, 32'h7FFF_FFFF, 9'd7,  32'h0, "R5");
    step(4, 32'h300, 32'hFFFF_FFFF, 9'd7,  32'h0, "R5");
    step(2, 32'h4000, 32'h9,       9'h1FF, 32'h0, "R6");
    step(1, 32'hFFFF_FFFC, 32'h5,  9'd2,   32'h0, "R7");
    step(5, 32'h800, 32'h0,        9'h1FE, 32'h0, "R8");
    step(5, 32'hFFFF_FFFC, 32'h3,  9'd1,   32'h0, "R8");
    step(6, 32'h900, 32'h0,        9'd9,   32'hDEAD_BEE0, "R9");
    step(0, 32'hA00, 32'h0,        9'd9,   32'h1111_0000, "R10");
    step(7, 32'hA04, 32'h0,        9'd9,   32'h2222_0000, "R10");
    step(1, 32'h1000, 32'h0,       9'h100, 32'h0, "R11");
    step(2, 32'h1000, 32'h1,       9'h0FF, 32'h0, "R11");
    step(5, 32'h0,   32'h0,        9'h100, 32'h0, "R11");
    step(3, 32'hFFFF_FF00, 32'h8000_0000, 9'h0FF, 32'h0, "R11");
    for (int i = 0; i < 600; i++) begin
      step(int'($urandom_range(0, 7)), $urandom, (i % 5 == 0) ? 32'h0 : $urandom,
           9'($urandom), $urandom, "R2");
    end
    @(negedge clk);
    compare_pending();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule